// File: doc/BRIEF.md
# Packet Transmit Framer

This block turns a payload stored in a byte-addressed packet buffer into a serial frame, one chip per clock. A single start pulse makes it emit an optional repeated preamble byte, an optional sync word of programmable length, the payload bytes fetched from the buffer, and an optional 16-bit CRC computed over the payload. The payload and CRC can be sent as they are, Manchester encoded, or whitened with a pseudo-random sequence. The preamble and sync word are never coded.

The host fills the buffer, sets the configuration inputs and pulses `start_i`. The framer captures the whole configuration on that edge. From the next cycle `tx_valid_o` marks every cycle that carries a chip on `tx_bit_o`. When the frame has been sent, `done_o` pulses. The buffer read port is combinational: `buf_data_i` must present the byte at `buf_addr_o` within the same cycle.

Top module: `pkt_tx_framer`

## Requirements
- R1: An accepted start makes the first chip appear in the next cycle. The fields follow in the order preamble, sync, payload, CRC. Every field bit is sent MSB first, with `tx_valid_o` high and no gaps, one chip per cycle.
- R2: The preamble is `pre_pat_i` sent (`pre_len_i` + 1) times, for 1 to 32 bytes.
- R3: The sync field is the low N bits of `sync_word_i`, bit N-1 first, where N = `sync_len_i`. Values below 8 are treated as 8 and values above 32 are treated as 32.
- R4: Payload byte k is read from buffer address k, for k = 0 to `pay_len_i`-1. A length of 0 sends no payload.
- R5: The CRC uses polynomial 0x1021. It starts from `crc_init_i`, absorbs the raw payload bits MSB first and is sent bit 15 first.
- R6: `pre_en_i`, `sync_en_i` and `crc_en_i` each remove their field when low. A frame with no fields and no payload gives `done_o` in the first cycle after start, with no valid chip.
- R7: `code_mode_i` encodes 0 = plain, 1 = Manchester, 2 = whitening, 3 = plain. In Manchester mode each payload/CRC bit becomes two chips: 1 is sent as 1 then 0, and 0 as 0 then 1.
- R8: In whitening mode each payload/CRC bit is XORed with s[0] of a 9-bit register s. The register is set to all ones at start and steps once per payload/CRC bit to {s[0]^s[5], s[8:1]}. The CRC is computed over the unwhitened payload.
- R9: `done_o` is high for exactly one cycle, the cycle right after the last chip, and `tx_valid_o` is low in that cycle.
- R10: A start while a frame is in progress, including the `done_o` cycle, is ignored. Configuration changes after an accepted start do not affect that frame.
- R11: During reset `tx_valid_o`, `tx_bit_o` and `done_o` are low, and `tx_bit_o` is low whenever `tx_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a frame (accepted only when idle) |
| pre_en_i | input | 1 | Include preamble |
| pre_len_i | input | 5 | Preamble byte count minus one |
| pre_pat_i | input | 8 | Preamble byte pattern |
| sync_en_i | input | 1 | Include sync word |
| sync_len_i | input | 6 | Sync word length in bits (8..32) |
| sync_word_i | input | 32 | Sync word, right aligned |
| pay_len_i | input | 8 | Payload length in bytes |
| crc_en_i | input | 1 | Append CRC |
| crc_init_i | input | 16 | CRC initial value |
| code_mode_i | input | 2 | Payload/CRC coding select |
| buf_addr_o | output | 8 | Packet buffer read address |
| buf_data_i | input | 8 | Packet buffer read data |
| tx_bit_o | output | 1 | Serial chip |
| tx_valid_o | output | 1 | Chip valid strobe |
| done_o | output | 1 | Frame complete pulse |

## Verification
The bench uses the default parameters: an 8-bit buffer address, up to 32 preamble bytes and up to 32 sync bits. With these values the longest preamble and the full 32-bit sync word are within reach, along with both ends of the sync length clamp and 16-byte payloads that drive the CRC and whitening sequence over many steps. The bench compares each frame against a bit-exact model built from the requirements. One frame is disturbed by a mid-frame start and by configuration changes, and the bench checks that neither has any effect.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;
  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam int WHT_W = 9;
  localparam int WHT_TAP = 5;

  typedef enum logic [1:0] {
    CODE_NONE   = 2'd0,
    CODE_MANCH  = 2'd1,
    CODE_WHITEN = 2'd2,
    CODE_RSVD   = 2'd3
  } code_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_PRE, PH_SYNC, PH_PAY, PH_CRC, PH_DONE
  } phase_e;

  // first enabled field strictly after cur
  function automatic phase_e next_phase(phase_e cur, logic pre, logic sync, logic pay, logic crc);
    phase_e r;
    r = PH_DONE;
    if (crc  && cur < PH_CRC)  r = PH_CRC;
    if (pay  && cur < PH_PAY)  r = PH_PAY;
    if (sync && cur < PH_SYNC) r = PH_SYNC;
    if (pre  && cur < PH_PRE)  r = PH_PRE;
    return r;
  endfunction
endpackage

// File: rtl/pkt_tx_crc16.sv
module pkt_tx_crc16 import pkt_tx_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CRC_W-1:0] init_i,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q, crc_d;
  logic fb;

  always_comb begin
    fb    = crc_q[CRC_W-1] ^ bit_i;
    crc_d = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '0;
    else if (load_i)  crc_q <= init_i;
    else if (shift_i) crc_q <= crc_d;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/pkt_tx_whiten.sv
module pkt_tx_whiten import pkt_tx_pkg::*; #(
  parameter int W   = WHT_W,
  parameter int TAP = WHT_TAP
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic seed_i,
  input  logic step_i,
  output logic mask_o
);
  logic [W-1:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     s_q <= '1;
    else if (seed_i) s_q <= '1;
    else if (step_i) s_q <= {s_q[0] ^ s_q[TAP], s_q[W-1:1]};
  end

  assign mask_o = s_q[0];
endmodule

// File: rtl/pkt_tx_framer.sv
module pkt_tx_framer import pkt_tx_pkg::*; #(
  parameter int ADDR_W   = 8,
  parameter int PRE_MAX  = 32,
  parameter int SYNC_MAX = 32,
  localparam int PRE_W   = $clog2(PRE_MAX),
  localparam int SYNC_LW = $clog2(SYNC_MAX + 1),
  localparam int BIT_W   = $clog2(SYNC_MAX)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                pre_en_i,
  input  logic [PRE_W-1:0]    pre_len_i,
  input  logic [7:0]          pre_pat_i,
  input  logic                sync_en_i,
  input  logic [SYNC_LW-1:0]  sync_len_i,
  input  logic [SYNC_MAX-1:0] sync_word_i,
  input  logic [ADDR_W-1:0]   pay_len_i,
  input  logic                crc_en_i,
  input  logic [CRC_W-1:0]    crc_init_i,
  input  logic [1:0]          code_mode_i,
  output logic [ADDR_W-1:0]   buf_addr_o,
  input  logic [7:0]          buf_data_i,
  output logic                tx_bit_o,
  output logic                tx_valid_o,
  output logic                done_o
);
  phase_e              ph_q;
  logic [BIT_W-1:0]    bit_q;
  logic [ADDR_W-1:0]   byte_q;
  logic                half_q;
  logic [PRE_W-1:0]    pre_last_q;
  logic [7:0]          pat_q;
  logic                sync_en_q, crc_en_q, pay_nz_q;
  logic [BIT_W-1:0]    sync_last_q, sync_last_d, sync_idx;
  logic [SYNC_MAX-1:0] sync_q;
  logic [ADDR_W-1:0]   pay_last_q;
  code_e               mode_q;
  logic [CRC_W-1:0]    crc_w;
  logic                mask_w, raw, chip, coded_ph, manch, whiten, step, last, start_ok;

  assign start_ok = start_i && (ph_q == PH_IDLE);
  assign coded_ph = (ph_q == PH_PAY) || (ph_q == PH_CRC);
  assign manch    = (mode_q == CODE_MANCH);
  assign whiten   = (mode_q == CODE_WHITEN);
  assign step     = !(coded_ph && manch && !half_q);
  assign sync_idx = sync_last_q - bit_q;

  always_comb begin
    if (sync_len_i < SYNC_LW'(8))             sync_last_d = BIT_W'(7);
    else if (sync_len_i > SYNC_LW'(SYNC_MAX)) sync_last_d = BIT_W'(SYNC_MAX - 1);
    else                                      sync_last_d = BIT_W'(sync_len_i - 1'b1);
  end

  always_comb begin
    raw  = 1'b0;
    last = 1'b0;
    case (ph_q)
      PH_PRE: begin
        raw  = pat_q[~bit_q[2:0]];
        last = (bit_q[2:0] == 3'd7) && (byte_q == ADDR_W'(pre_last_q));
      end
      PH_SYNC: begin
        raw  = sync_q[sync_idx];
        last = (bit_q == sync_last_q);
      end
      PH_PAY: begin
        raw  = buf_data_i[~bit_q[2:0]];
        last = (bit_q[2:0] == 3'd7) && (byte_q == pay_last_q);
      end
      PH_CRC: begin
        raw  = crc_w[~bit_q[3:0]];
        last = (bit_q == BIT_W'(CRC_W - 1));
      end
      default: ;
    endcase
  end

  always_comb begin
    chip = raw;
    if (coded_ph && whiten)     chip = raw ^ mask_w;
    else if (coded_ph && manch) chip = raw ^ half_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q        <= PH_IDLE;
      bit_q       <= '0;
      byte_q      <= '0;
      half_q      <= 1'b0;
      pre_last_q  <= '0;
      pat_q       <= '0;
      sync_en_q   <= 1'b0;
      crc_en_q    <= 1'b0;
      pay_nz_q    <= 1'b0;
      sync_last_q <= '0;
      sync_q      <= '0;
      pay_last_q  <= '0;
      mode_q      <= CODE_NONE;
    end else if (start_ok) begin
      ph_q        <= next_phase(PH_IDLE, pre_en_i, sync_en_i, pay_len_i != '0, crc_en_i);
      bit_q       <= '0;
      byte_q      <= '0;
      half_q      <= 1'b0;
      pre_last_q  <= pre_len_i;
      pat_q       <= pre_pat_i;
      sync_en_q   <= sync_en_i;
      crc_en_q    <= crc_en_i;
      pay_nz_q    <= (pay_len_i != '0);
      sync_last_q <= sync_last_d;
      sync_q      <= sync_word_i;
      pay_last_q  <= pay_len_i - 1'b1;
      mode_q      <= code_e'(code_mode_i);
    end else begin
      case (ph_q)
        PH_DONE: ph_q <= PH_IDLE;
        PH_PRE, PH_SYNC, PH_PAY, PH_CRC: begin
          if (coded_ph && manch) half_q <= ~half_q;
          if (step) begin
            if (last) begin
              ph_q   <= next_phase(ph_q, 1'b0, sync_en_q, pay_nz_q, crc_en_q);
              bit_q  <= '0;
              byte_q <= '0;
            end else if ((ph_q == PH_PRE) || (ph_q == PH_PAY)) begin
              if (bit_q[2:0] == 3'd7) begin
                bit_q  <= '0;
                byte_q <= byte_q + 1'b1;
              end else begin
                bit_q <= bit_q + 1'b1;
              end
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  pkt_tx_crc16 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_ok),
    .init_i (crc_init_i),
    .shift_i(step && (ph_q == PH_PAY)),
    .bit_i  (raw),
    .crc_o  (crc_w)
  );

  pkt_tx_whiten u_wht (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .seed_i(start_ok),
    .step_i(step && coded_ph),
    .mask_o(mask_w)
  );

  assign tx_valid_o = (ph_q == PH_PRE) || (ph_q == PH_SYNC) || coded_ph;
  assign tx_bit_o   = tx_valid_o & chip;
  assign done_o     = (ph_q == PH_DONE);
  assign buf_addr_o = byte_q;
endmodule

// File: rtl/pkt_tx_framer_chk.sv
module pkt_tx_framer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_bit_o,
  input logic tx_valid_o,
  input logic done_o
);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_valid_o) |-> done_o);

  // R9
  done_no_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !tx_valid_o);

  // R10
  done_then_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !tx_valid_o);

  // R11
  idle_bit_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_valid_o |-> !tx_bit_o);

  // R11
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_quiet_chk: assert (!tx_valid_o && !tx_bit_o && !done_o);
    end
  end
endmodule

bind pkt_tx_framer pkt_tx_framer_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_bit_o  (tx_bit_o),
  .tx_valid_o(tx_valid_o),
  .done_o    (done_o)
);

// File: tb/pkt_tx_framer_test.sv
module pkt_tx_framer_test;
  typedef struct packed {
    logic        pre_en;
    logic [4:0]  pre_len;
    logic [7:0]  pre_pat;
    logic        sync_en;
    logic [5:0]  sync_len;
    logic [31:0] sync_word;
    logic [7:0]  pay_len;
    logic        crc_en;
    logic [15:0] crc_init;
    logic [1:0]  mode;
    logic [7:0]  seed;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 5'd1,  8'hAA, 1'b1, 6'd16, 32'h00002DD4, 8'd4,  1'b1, 16'hFFFF, 2'd0, 8'h10, 4'd1},
    '{1'b1, 5'd31, 8'h55, 1'b0, 6'd8,  32'h00000000, 8'd1,  1'b0, 16'h0000, 2'd0, 8'h3C, 4'd2},
    '{1'b0, 5'd0,  8'h00, 1'b1, 6'd32, 32'h9E3779B9, 8'd2,  1'b1, 16'h0000, 2'd0, 8'h77, 4'd3},
    '{1'b1, 5'd0,  8'hF0, 1'b1, 6'd8,  32'h000000A5, 8'd3,  1'b1, 16'h1D0F, 2'd1, 8'h01, 4'd7},
    '{1'b1, 5'd0,  8'hCC, 1'b1, 6'd24, 32'h00ABCDEF, 8'd5,  1'b1, 16'hFFFF, 2'd2, 8'hE1, 4'd8},
    '{1'b0, 5'd0,  8'h00, 1'b0, 6'd8,  32'h00000000, 8'd0,  1'b1, 16'hB38F, 2'd0, 8'h00, 4'd6},
    '{1'b0, 5'd0,  8'h00, 1'b0, 6'd8,  32'h00000000, 8'd16, 1'b1, 16'hFFFF, 2'd0, 8'h5A, 4'd5},
    '{1'b1, 5'd2,  8'h0F, 1'b1, 6'd12, 32'h00000ABC, 8'd2,  1'b1, 16'h1234, 2'd3, 8'h99, 4'd4}
  };

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic pre_en_i = 1'b0, sync_en_i = 1'b0, crc_en_i = 1'b0;
  logic [4:0] pre_len_i = '0;
  logic [7:0] pre_pat_i = '0;
  logic [5:0] sync_len_i = 6'd8;
  logic [31:0] sync_word_i = '0;
  logic [7:0] pay_len_i = '0;
  logic [15:0] crc_init_i = '0;
  logic [1:0] code_mode_i = '0;
  logic [7:0] buf_addr_o, buf_data_i;
  logic tx_bit_o, tx_valid_o, done_o;

  logic [7:0] mem [256];
  assign buf_data_i = mem[buf_addr_o];

  int tests = 0, fails = 0;
  bit exp_bits [1024];
  int exp_n;
  logic [8:0] wht;

  always #5 clk = ~clk;

  pkt_tx_framer uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .pre_en_i(pre_en_i), .pre_len_i(pre_len_i), .pre_pat_i(pre_pat_i),
    .sync_en_i(sync_en_i), .sync_len_i(sync_len_i), .sync_word_i(sync_word_i),
    .pay_len_i(pay_len_i), .crc_en_i(crc_en_i), .crc_init_i(crc_init_i),
    .code_mode_i(code_mode_i), .buf_addr_o(buf_addr_o), .buf_data_i(buf_data_i),
    .tx_bit_o(tx_bit_o), .tx_valid_o(tx_valid_o), .done_o(done_o)
  );

  function automatic string tname(int t);
    case (t)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";  10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input bit b);
    exp_bits[exp_n] = b;
    exp_n++;
  endtask

  task automatic emit(input bit d, input logic [1:0] mode);
    if (mode == 2'd1) begin          // R7 Manchester pair
      push(d);
      push(~d);
    end else if (mode == 2'd2) begin // R8 whitening
      push(d ^ wht[0]);
      wht = {wht[0] ^ wht[5], wht[8:1]};
    end else begin
      push(d);
    end
  endtask

  task automatic build_exp(input vec_t v);
    logic [15:0] crc;
    int slen;
    exp_n = 0;
    if (v.pre_en)
      for (int b = 0; b <= int'(v.pre_len); b++)
        for (int i = 7; i >= 0; i--) push(v.pre_pat[i]);
    slen = (v.sync_len < 8) ? 8 : (v.sync_len > 32) ? 32 : int'(v.sync_len);
    if (v.sync_en)
      for (int i = slen - 1; i >= 0; i--) push(v.sync_word[i]);
    crc = v.crc_init;
    wht = 9'h1FF;
    for (int k = 0; k < int'(v.pay_len); k++)
      for (int i = 7; i >= 0; i--) begin
        bit d;
        d = mem[k][i];
        crc = {crc[14:0], 1'b0} ^ ((crc[15] ^ d) ? 16'h1021 : 16'h0000);
        emit(d, v.mode);
      end
    if (v.crc_en)
      for (int i = 15; i >= 0; i--) emit(crc[i], v.mode);
  endtask

  task automatic apply(input vec_t v);
    pre_en_i = v.pre_en;   pre_len_i = v.pre_len;   pre_pat_i = v.pre_pat;
    sync_en_i = v.sync_en; sync_len_i = v.sync_len; sync_word_i = v.sync_word;
    pay_len_i = v.pay_len; crc_en_i = v.crc_en;     crc_init_i = v.crc_init;
    code_mode_i = v.mode;
  endtask

  task automatic run_frame(input vec_t v, input bit disturb);
    int got, bad_at, cyc;
    bit seen_done, disturbed;
    for (int k = 0; k < 256; k++) mem[k] = v.seed + 8'(k * 37);
    build_exp(v);
    apply(v);
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    got = 0; bad_at = -1; cyc = 0; seen_done = 0; disturbed = 0;
    while (!seen_done && cyc < 5000) begin
      if (tx_valid_o) begin
        if (got >= exp_n || tx_bit_o != exp_bits[got]) begin
          if (bad_at < 0) bad_at = got;
        end
        got++;
      end
      if (done_o) seen_done = 1;
      if (disturb && !disturbed && got == 3) begin
        // R10: mid-frame start and config changes
        disturbed = 1;
        start_i = 1'b1;
        pre_pat_i = ~v.pre_pat; sync_word_i = ~v.sync_word; pay_len_i = 8'd9;
        crc_init_i = ~v.crc_init; code_mode_i = 2'd1; crc_en_i = ~v.crc_en;
        sync_len_i = 6'd20; pre_len_i = 5'd7;
      end
      if (!seen_done) begin
        @(negedge clk);
        cyc++;
      end
    end
    check(bad_at < 0 && got == exp_n, tname(int'(v.tag)), "frame chips (first bad index / count)",
          (bad_at < 0) ? got : bad_at, exp_n);
    check(seen_done, "R9", "done pulse seen", int'(seen_done), 1);
    if (disturb) begin
      @(negedge clk);
      start_i = 1'b0;
      begin
        int vcnt;
        vcnt = 0;
        for (int c = 0; c < 4; c++) begin
          if (tx_valid_o) vcnt++;
          @(negedge clk);
        end
        check(vcnt == 0, "R10", "valid chips after start during done", vcnt, 0);
      end
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    vec_t v;
    for (int k = 0; k < 256; k++) mem[k] = 8'h00;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!tx_valid_o && !tx_bit_o && !done_o, "R11", "outputs in reset",
          int'({tx_valid_o, tx_bit_o, done_o}), 0);
    start_i = 1'b1;
    @(negedge clk);
    check(!tx_valid_o && !done_o, "R11", "start ignored in reset",
          int'({tx_valid_o, done_o}), 0);
    start_i = 1'b0;
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    for (int n = 0; n < NV; n++) run_frame(VECS[n], 1'b0);

    // R3 sync length below range clamps to 8
    v = VECS[2]; v.sync_len = 6'd3; v.sync_word = 32'h0000C3A5;
    run_frame(v, 1'b0);
    // R3 sync length above range clamps to 32
    v = VECS[2]; v.sync_len = 6'd40; v.sync_word = 32'hF00D1234;
    run_frame(v, 1'b0);
    // R6 empty frame: nothing enabled, no payload
    v = VECS[5]; v.crc_en = 1'b0; v.tag = 4'd6;
    run_frame(v, 1'b0);
    // R10 disturbances ignored
    v = VECS[0]; v.tag = 4'd10;
    run_frame(v, 1'b1);
    // R7 Manchester with preamble off, CRC off
    v = VECS[3]; v.pre_en = 1'b0; v.crc_en = 1'b0; v.pay_len = 8'd6;
    run_frame(v, 1'b0);
    // R8 whitening across a long payload
    v = VECS[4]; v.pay_len = 8'd16; v.sync_en = 1'b0;
    run_frame(v, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule